// File: doc/BRIEF.md
# I2C Bus Condition Status Monitor

This block watches the SCL and SDA lines of an I2C bus. It detects START, repeated START and STOP conditions and keeps an 8-bit, read-only status byte for the surrounding controller. Each line passes through a synchronizer chain of configurable depth. Edge detection then runs on the system clock: a START is SDA falling while SCL stays high, and a STOP is SDA rising while SCL stays high.

Two flags live in the block. The bus-busy flag in bit 7 sets on any START and clears on a STOP. The repeated-START flag in bit 6 sets when a START arrives while the bus is already busy. Several controller events clear it:

- a STOP;
- a software write of zero to the interrupt flag;
- in slave mode only, an address phase that ends badly: no match on the own address, a match while acknowledge is disabled, or a general call while general-call acknowledge is off.

Bit 5 always reads 0. Bits 4:0 are status bits from the rest of the controller and pass straight through to the read port. Address decoding, shifting and acknowledge generation are outside this block; it only consumes their results.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset, status bits 7 and 6 read 0 and bit 5 reads 0.
- R2: A START on an idle bus (SDA falls while SCL is high) sets bit 7 (busy) and leaves bit 6 at 0.
- R3: A STOP (SDA rises while SCL is high) clears both bit 7 and bit 6.
- R4: A START while bit 7 is 1 sets bit 6 (repeated START); bit 6 is never 1 while bit 7 is 0.
- R5: A one-cycle pulse on intClrWr clears bit 6 and leaves bit 7 unchanged.
- R6: With slaveMode=1, an addrDone pulse with addrMatch=0 and genCallRcvd=0 clears bit 6.
- R7: With slaveMode=1, an addrDone pulse with addrMatch=1, genCallRcvd=0 and ackDisable=1 clears bit 6; with ackDisable=0 bit 6 is kept.
- R8: With slaveMode=1, an addrDone pulse with genCallRcvd=1 and genCallAckEn=0 clears bit 6; with genCallAckEn=1 bit 6 is kept.
- R9: With slaveMode=0, addrDone pulses leave bit 6 unchanged whatever addrMatch, ackDisable, genCallRcvd and genCallAckEn are.
- R10: status[5] is always 0, and status[4:0] equals lowerBits in the same cycle.
- R11: SDA changes while SCL is low change neither bit 7 nor bit 6.
- R12: If a repeated START and a non-STOP clear event (such as intClrWr) land in the same clock cycle, bit 6 ends up 1. A STOP clears it in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| intClrWr | input | 1 | Pulse: software wrote 0 to the interrupt flag |
| slaveMode | input | 1 | Controller is operating as a slave |
| addrDone | input | 1 | Pulse: address phase finished, compare results valid |
| addrMatch | input | 1 | Received address equals own address |
| ackDisable | input | 1 | Acknowledge-disable control is set |
| genCallRcvd | input | 1 | Received address is the general-call address |
| genCallAckEn | input | 1 | General-call acknowledge is enabled |
| lowerBits | input | 5 | Status bits 4:0 from the rest of the controller |
| status | output | 8 | Status byte: {busy, rptStart, 0, lowerBits} |

## Verification
Directed bus sequences show the following:

- START then STOP separates a plain START from a repeated one.
- SDA toggling while SCL is low shows that data bits never look like conditions.
- Each slave address outcome is paired with its keep or clear counterpart. This shows that only the three bad outcomes clear the flag, and only in slave mode.
- A software clear is timed into the same cycle as a repeated-START strobe to check the set-over-clear priority.

A seeded random mix of bus conditions, clear events and lower-bit values then runs against a bench model of both flags.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int STATUS_W = 8;
  localparam int LOW_W    = 5;

  typedef struct packed {
    logic start;   // START seen (idle or busy bus)
    logic stop;    // STOP seen
    logic rscClr;  // non-STOP event that clears the repeated-START flag
  } condStb_t;
endpackage

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     intClrWr,
  input  logic     slaveMode,
  input  logic     addrDone,
  input  logic     addrMatch,
  input  logic     ackDisable,
  input  logic     genCallRcvd,
  input  logic     genCallAckEn,
  output condStb_t stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclSh;
  logic [LAST:0] sdaSh;
  logic          sclPrev;
  logic          sdaPrev;
  logic          sclNow;
  logic          sdaNow;

  // Synchronizer chains; an idle I2C line is high, so reset to 1.
  generate
    if (SYNC_STAGES < 2) begin : g_badDepth
      initial $error("SYNC_STAGES must be at least 2");
    end
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh[i] <= 1'b1;
          sdaSh[i] <= 1'b1;
        end else if (i == 0) begin
          sclSh[i] <= sclIn;
          sdaSh[i] <= sdaIn;
        end else begin
          sclSh[i] <= sclSh[(i == 0) ? 0 : i - 1];
          sdaSh[i] <= sdaSh[(i == 0) ? 0 : i - 1];
        end
      end
    end
  endgenerate

  assign sclNow = sclSh[LAST];
  assign sdaNow = sdaSh[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic sclHeld;
  logic addrMiss;
  logic ackOff;
  logic gcNack;

  always_comb begin
    sclHeld   = sclNow & sclPrev;
    addrMiss  = slaveMode & addrDone & ~genCallRcvd & ~addrMatch;
    ackOff    = slaveMode & addrDone & ~genCallRcvd & addrMatch & ackDisable;
    gcNack    = slaveMode & addrDone & genCallRcvd & ~genCallAckEn;
    stb.start  = sclHeld & sdaPrev & ~sdaNow;
    stb.stop   = sclHeld & ~sdaPrev & sdaNow;
    stb.rscClr = intClrWr | addrMiss | ackOff | gcNack;
  end
endmodule

// File: rtl/i2c_cond_datapath.sv
module i2c_cond_datapath
  import i2c_cond_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  condStb_t            stb,
  input  logic [LOW_W-1:0]    lowerBits,
  output logic [STATUS_W-1:0] status
);
  logic busyQ;
  logic rscQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      rscQ  <= 1'b0;
    end else begin
      // STOP wins over everything; a restart wins over other clears.
      if (stb.stop) begin
        busyQ <= 1'b0;
        rscQ  <= 1'b0;
      end else if (stb.start) begin
        busyQ <= 1'b1;
        if (busyQ) rscQ <= 1'b1;
        else if (stb.rscClr) rscQ <= 1'b0;
      end else if (stb.rscClr) begin
        rscQ <= 1'b0;
      end
    end
  end

  assign status = {busyQ, rscQ, 1'b0, lowerBits};
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                intClrWr,
  input  logic                slaveMode,
  input  logic                addrDone,
  input  logic                addrMatch,
  input  logic                ackDisable,
  input  logic                genCallRcvd,
  input  logic                genCallAckEn,
  input  logic [LOW_W-1:0]    lowerBits,
  output logic [STATUS_W-1:0] status
);
  condStb_t stb;

  i2c_cond_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .intClrWr(intClrWr), .slaveMode(slaveMode), .addrDone(addrDone),
    .addrMatch(addrMatch), .ackDisable(ackDisable),
    .genCallRcvd(genCallRcvd), .genCallAckEn(genCallAckEn), .stb(stb)
  );

  i2c_cond_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lowerBits(lowerBits), .status(status)
  );
endmodule

// File: rtl/i2c_cond_monitor_chk.sv
module i2c_cond_monitor_chk
  import i2c_cond_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input condStb_t            stb,
  input logic                intClrWr,
  input logic                slaveMode,
  input logic [STATUS_W-1:0] status
);
  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && !stb.stop) |=> status[7]);

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> (!status[7] && !status[6]));

  // R4
  restart_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && status[7]) |=> status[6]);

  // R4
  rsc_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[6] |-> status[7]);

  // R5
  swclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intClrWr && !stb.start && !stb.stop) |=> (!status[6] && $stable(status[7])));

  // R9
  master_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !intClrWr && !stb.start && !stb.stop) |=> $stable(status[6]));
endmodule

bind i2c_cond_monitor i2c_cond_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .intClrWr(intClrWr),
  .slaveMode(slaveMode), .status(status)
);

// File: tb/i2c_cond_monitor_bench.sv
module i2c_cond_monitor_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1;
  logic       intClrWr = 1'b0, slaveMode = 1'b0, addrDone = 1'b0;
  logic       addrMatch = 1'b0, ackDisable = 1'b0;
  logic       genCallRcvd = 1'b0, genCallAckEn = 1'b0;
  logic [4:0] lowerBits = 5'd0;
  logic [7:0] status;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic expBusy = 1'b0, expRsc = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_cond_monitor u_i2c_cond_monitor (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .intClrWr(intClrWr), .slaveMode(slaveMode), .addrDone(addrDone),
    .addrMatch(addrMatch), .ackDisable(ackDisable),
    .genCallRcvd(genCallRcvd), .genCallAckEn(genCallAckEn),
    .lowerBits(lowerBits), .status(status)
  );

  function automatic logic [7:0] expStatus(logic b, logic r, logic [4:0] lo);
    return {b, r, 1'b0, lo};
  endfunction

  // Clear rule from R5..R9
  function automatic logic clrHit(logic sw, logic sl, logic ad, logic am,
                                  logic ak, logic gc, logic ge);
    if (sw) return 1'b1;
    if (!(sl && ad)) return 1'b0;
    if (gc) return !ge;
    return !am || ak;
  endfunction

  task automatic chk(string req);
    logic [7:0] e;
    e = expStatus(expBusy, expRsc, lowerBits);
    checks++;
    if (status !== e) begin
      errors++;
      $display("FAIL %s: status=%b expected=%b", req, status, e);
    end
  endtask

  task automatic busStep(logic c, logic d);
    sclIn = c;
    sdaIn = d;
    repeat (5) @(negedge clk);
  endtask

  task automatic doStart();
    busStep(1'b0, sdaIn);
    busStep(1'b0, 1'b1);
    busStep(1'b1, 1'b1);
    busStep(1'b1, 1'b0);
    expRsc  = expBusy;
    expBusy = 1'b1;
    busStep(1'b0, 1'b0);
  endtask

  task automatic doStop();
    busStep(1'b0, sdaIn);
    busStep(1'b0, 1'b0);
    busStep(1'b1, 1'b0);
    busStep(1'b1, 1'b1);
    expBusy = 1'b0;
    expRsc  = 1'b0;
  endtask

  task automatic pulse(logic sw, logic sl, logic ad, logic am,
                       logic ak, logic gc, logic ge);
    slaveMode = sl; addrMatch = am; ackDisable = ak;
    genCallRcvd = gc; genCallAckEn = ge;
    intClrWr = sw; addrDone = ad;
    @(negedge clk);
    intClrWr = 1'b0; addrDone = 1'b0;
    if (clrHit(sw, sl, ad, am, ak, gc, ge)) expRsc = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic toRestart();
    if (!expBusy) doStart();
    doStart();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C2A_5EED));
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset release");

    // R10 pass-through in same cycle
    lowerBits = 5'b10110; #0.5; chk("R10 lower bits");
    lowerBits = 5'b01001; #0.5; chk("R10 lower bits");

    // R11 data toggles with SCL low
    busStep(1'b0, 1'b1);
    busStep(1'b0, 1'b0); busStep(1'b0, 1'b1); busStep(1'b0, 1'b0);
    chk("R11 idle data toggles");

    doStart(); chk("R2 start on idle");
    busStep(1'b0, 1'b1); busStep(1'b0, 1'b0);
    chk("R11 busy data toggles");
    doStart(); chk("R4 repeated start");
    doStop();  chk("R3 stop clears");

    toRestart(); pulse(1,0,0,0,0,0,0); chk("R5 software clear");
    toRestart(); pulse(0,1,1,0,0,0,0); chk("R6 address miss");
    toRestart(); pulse(0,1,1,1,0,0,0); chk("R7 match with ack kept");
    pulse(0,1,1,1,1,0,0); chk("R7 match with ack disabled");
    toRestart(); pulse(0,1,1,0,0,1,1); chk("R8 general call acked");
    pulse(0,1,1,0,0,1,0); chk("R8 general call nacked");
    toRestart();
    pulse(0,0,1,0,0,0,0); chk("R9 master miss");
    pulse(0,0,1,1,1,0,0); chk("R9 master ack disabled");
    pulse(0,0,1,0,0,1,0); chk("R9 master gc nack");

    // R12: software clear lands on the restart strobe cycle
    doStop(); doStart();
    busStep(1'b0, 1'b1); busStep(1'b1, 1'b1);
    sdaIn = 1'b0;
    @(negedge clk); @(negedge clk);
    intClrWr = 1'b1;
    @(negedge clk);
    intClrWr = 1'b0;
    expRsc = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 restart beats software clear");
    busStep(1'b0, 1'b0);
    doStop(); chk("R12 stop always clears");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      lowerBits = 5'($urandom);
      case (op)
        0, 1: doStart();
        2: doStop();
        3: begin busStep(1'b0, 1'b1); busStep(1'b0, 1'b0); end
        default: pulse(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom));
      endcase
      chk("R12 random mix");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule